// File: doc/BRIEF.md
# Radio Packet Transmit Framer

This block turns payload bytes, queued in an internal transmit FIFO, into a serial bit stream for a radio modulator. Each packet is assembled from a run of alternating-bit preamble bytes, a start pattern, an optional node address byte, an optional length byte, the payload and an optional 16-bit CRC. Optionally, everything after the start pattern can be Manchester coded or XOR-scrambled to keep the line DC-balanced.

The host fills the FIFO through a byte-write port, sets the configuration inputs and pulses `start`. The framer then emits one bit slot on each `bit_tick` from the external data-rate generator. `done` pulses when a packet is finished. `underflow` pulses instead if the FIFO runs dry before the payload is complete. The configuration must stay stable while `busy` is high.

Top module: `pkt_tx_framer`

## Requirements
- R1: A packet begins with `cfg_pre_len` preamble bytes of value 0xAA, followed by the SYNC_W bits of `cfg_sync`. Every field goes out most significant bit first. With `cfg_pre_len` of 0, the packet starts directly with the start pattern.
- R2: The byte `cfg_addr` follows the start pattern only when `cfg_addr_en` is 1.
- R3: A length byte equal to `cfg_len` is sent after the address position only when `cfg_var_len` is 1.
- R4: Exactly `cfg_len` payload bytes follow, taken from the FIFO in write order. A length of 0 sends no payload.
- R5: When `cfg_crc_en` is 1, a CRC-16 with polynomial 0x1021 and initial value 0xFFFF closes the packet. It is computed over the uncoded address, length and payload bits and sent MSB first.
- R6: With `cfg_code` = 1, each bit from the address field onward becomes two slots: 1 is sent as 1 then 0, and 0 is sent as 0 then 1. Preamble and start pattern are never coded. `cfg_code` values 0 and 3 send every field uncoded.
- R7: With `cfg_code` = 2, each bit from the address field onward is XORed with bit 8 of a 9-bit shift register. The register is set to all ones at `start` and shifted once per bit, with its new bit 0 equal to bit 8 XOR bit 4.
- R8: Each `bit_tick` during a packet places one slot on `tx_bit` and raises `tx_stb` for one clock. On the first tick after the last slot, `done` pulses for one clock and `busy` falls.
- R9: If a payload byte is due while the FIFO is empty, `underflow` pulses, the packet stops after the slot in progress and `done` is not raised.
- R10: `fifo_full` is 1 while DEPTH bytes are held. A write while full is dropped.
- R11: `start` is ignored while `busy` is high.
- R12: After reset the framer is idle, with `busy`, `tx_stb`, `done`, `underflow` and `fifo_full` all 0 and the FIFO empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pre_len | input | PRE_W | Number of preamble bytes |
| cfg_sync | input | SYNC_W | Start pattern |
| cfg_addr_en | input | 1 | Send address byte |
| cfg_addr | input | 8 | Node address |
| cfg_var_len | input | 1 | Send length byte |
| cfg_len | input | 8 | Payload byte count |
| cfg_crc_en | input | 1 | Append CRC |
| cfg_code | input | 2 | 1 Manchester, 2 scramble, other uncoded |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | 8 | FIFO write byte |
| fifo_full | output | 1 | FIFO holds DEPTH bytes |
| start | input | 1 | Begin a packet |
| bit_tick | input | 1 | Data-rate bit enable |
| tx_bit | output | 1 | Serial output slot |
| tx_stb | output | 1 | New slot on tx_bit |
| busy | output | 1 | Packet in progress |
| done | output | 1 | Packet finished |
| underflow | output | 1 | Packet aborted, FIFO empty |

## Verification
`tx_bit` and `tx_stb` are registered, so they change one clock after the edge that samples `bit_tick`. The bench therefore samples on the falling edge that follows and collects a slot whenever `tx_stb` is seen high. `done` and `underflow` appear one clock after the tick that ends or aborts the packet, and are read in the same falling-edge sweep. `fifo_full` reflects a write one clock after it. Each collected stream is compared slot by slot with a packet that the bench builds from the requirements, including its own CRC and scrambler model.

// File: rtl/pkt_tx_framer.sv
module pkt_tx_framer #(
  parameter int DEPTH  = 64,
  parameter int PRE_W  = 4,
  parameter int SYNC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PRE_W-1:0]  cfg_pre_len,
  input  logic [SYNC_W-1:0] cfg_sync,
  input  logic              cfg_addr_en,
  input  logic [7:0]        cfg_addr,
  input  logic              cfg_var_len,
  input  logic [7:0]        cfg_len,
  input  logic              cfg_crc_en,
  input  logic [1:0]        cfg_code,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic              fifo_full,
  input  logic              start,
  input  logic              bit_tick,
  output logic              tx_bit,
  output logic              tx_stb,
  output logic              busy,
  output logic              done,
  output logic              underflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(SYNC_W > 16 ? SYNC_W : 16);
  localparam int CW = PRE_W > 8 ? PRE_W : 8;

  typedef enum logic [2:0] {IDLE, PRE, SYNC, ADDR, LEN, PAY, CRC, FIN} ph_t;

  ph_t ph, nxt;
  logic [PW-1:0] pos;
  logic [CW-1:0] cnt;
  logic [7:0]    cur;
  logic [15:0]   crc, crc_nx;
  logic [8:0]    lfsr;
  logic          half, held, raw;
  logic [7:0]    en_v;
  logic          coded, man, scr, live, first_half, upd_crc, last_byte, fld_end, pop, empty, wr_ok;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] rd_p, wr_p;
  logic [AW:0]   fcnt;

  function automatic logic [PW-1:0] top_pos(ph_t p);
    case (p)
      SYNC:    return PW'(SYNC_W - 1);
      CRC:     return PW'(15);
      default: return PW'(7);
    endcase
  endfunction

  assign en_v = {1'b1, cfg_crc_en, cfg_len != 8'd0, cfg_var_len, cfg_addr_en, 1'b1,
                 cfg_pre_len != '0, 1'b0};

  always_comb begin
    nxt = FIN;
    for (int k = 6; k >= 1; k--)
      if (k > int'(ph) && en_v[k]) nxt = ph_t'(3'(k));
  end

  always_comb begin
    case (ph)
      PRE:     raw = pos[0];
      SYNC:    raw = cfg_sync[pos];
      ADDR:    raw = cfg_addr[pos[2:0]];
      LEN:     raw = cfg_len[pos[2:0]];
      PAY:     raw = cur[pos[2:0]];
      CRC:     raw = crc[pos[3:0]];
      default: raw = 1'b0;
    endcase
  end

  assign busy       = ph != IDLE;
  assign coded      = (ph >= ADDR) && (ph <= CRC);
  assign man        = coded && cfg_code == 2'd1;
  assign scr        = coded && cfg_code == 2'd2;
  assign live       = bit_tick && ph != IDLE && ph != FIN;
  assign first_half = live && man && !half;
  assign upd_crc    = live && coded && ph != CRC && !(man && half);
  assign crc_nx     = {crc[14:0], 1'b0} ^ ((crc[15] ^ raw) ? 16'h1021 : 16'h0000);
  assign last_byte  = (ph == PRE) ? (cnt + CW'(1)) == CW'(cfg_pre_len) :
                      (ph == PAY) ? (cnt + CW'(1)) == CW'(cfg_len) : 1'b1;
  assign fld_end    = pos == '0 && last_byte;
  assign pop        = live && !first_half &&
                      ((fld_end && nxt == PAY) || (pos == '0 && !fld_end && ph == PAY));
  assign empty      = fcnt == '0;
  assign fifo_full  = fcnt == (AW+1)'(DEPTH);
  assign wr_ok      = wr_en && !fifo_full;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_p] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_p <= '0;
      wr_p <= '0;
      fcnt <= '0;
    end else begin
      if (wr_ok) wr_p <= (wr_p == AW'(DEPTH - 1)) ? '0 : wr_p + 1'b1;
      if (pop && !empty) rd_p <= (rd_p == AW'(DEPTH - 1)) ? '0 : rd_p + 1'b1;
      fcnt <= fcnt + (AW+1)'(wr_ok) - (AW+1)'(pop && !empty);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= IDLE;
      pos       <= '0;
      cnt       <= '0;
      cur       <= '0;
      crc       <= '0;
      lfsr      <= '0;
      half      <= 1'b0;
      held      <= 1'b0;
      tx_bit    <= 1'b0;
      tx_stb    <= 1'b0;
      done      <= 1'b0;
      underflow <= 1'b0;
    end else begin
      tx_stb    <= 1'b0;
      done      <= 1'b0;
      underflow <= 1'b0;
      if (ph == IDLE) begin
        if (start) begin
          ph   <= en_v[1] ? PRE : SYNC;
          pos  <= en_v[1] ? PW'(7) : PW'(SYNC_W - 1);
          cnt  <= '0;
          crc  <= 16'hFFFF;
          lfsr <= 9'h1FF;
          half <= 1'b0;
        end
      end else if (bit_tick && ph == FIN) begin
        ph   <= IDLE;
        done <= 1'b1;
      end else if (live) begin
        tx_stb <= 1'b1;
        if (upd_crc) crc <= crc_nx;
        if (first_half) begin
          tx_bit <= raw;
          held   <= raw;
          half   <= 1'b1;
        end else begin
          half   <= 1'b0;
          tx_bit <= man ? ~held : raw ^ (scr & lfsr[8]);
          if (scr) lfsr <= {lfsr[7:0], lfsr[8] ^ lfsr[4]};
          if (pop && empty) begin
            ph        <= IDLE;
            underflow <= 1'b1;
          end else begin
            if (pop) cur <= mem[rd_p];
            if (fld_end) begin
              ph  <= nxt;
              pos <= top_pos(nxt);
              cnt <= '0;
            end else if (pos == '0) begin
              pos <= PW'(7);
              cnt <= cnt + 1'b1;
            end else begin
              pos <= pos - 1'b1;
            end
          end
        end
      end
    end
  end

  a_r8_stb_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stb |-> $past(bit_tick) && $past(busy));
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !tx_stb && !busy);
  a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> !busy && !done);
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= (AW+1)'(DEPTH));
  a_r10_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !busy) |=> fifo_full);
endmodule

// File: tb/pkt_tx_framer_test.sv
module pkt_tx_framer_test;
  localparam logic [15:0] SYNCV = 16'hD391;
  // pre(4) addr_en var crc code(2) len(8) addr(8)
  localparam int NV = 7;
  localparam logic [24:0] VEC [NV] = '{
    {4'd2, 1'b0, 1'b0, 1'b0, 2'd0, 8'd3, 8'h00},
    {4'd3, 1'b1, 1'b1, 1'b1, 2'd0, 8'd5, 8'h5A},
    {4'd1, 1'b1, 1'b0, 1'b1, 2'd1, 8'd2, 8'hC3},
    {4'd0, 1'b0, 1'b1, 1'b1, 2'd2, 8'd4, 8'h00},
    {4'd4, 1'b1, 1'b1, 1'b0, 2'd2, 8'd6, 8'h81},
    {4'd2, 1'b0, 1'b0, 1'b1, 2'd1, 8'd0, 8'h00},
    {4'd1, 1'b0, 1'b1, 1'b0, 2'd3, 8'd1, 8'h00}
  };

  logic clk = 0, rst_n = 0;
  logic [3:0] cfg_pre_len = 0;
  logic [15:0] cfg_sync = SYNCV;
  logic cfg_addr_en = 0, cfg_var_len = 0, cfg_crc_en = 0;
  logic [7:0] cfg_addr = 0, cfg_len = 0;
  logic [1:0] cfg_code = 0;
  logic wr_en = 0, start = 0, bit_tick = 0;
  logic [7:0] wr_data = 0;
  logic fifo_full, tx_bit, tx_stb, busy, done, underflow;

  int checks = 0, failures = 0;
  logic [7:0] pay [64];
  logic exp_b [4096];
  logic got_b [4096];
  int nexp, ngot;
  logic dn, uf;

  always #5 clk = ~clk;

  pkt_tx_framer #(.DEPTH(64), .PRE_W(4), .SYNC_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_pre_len(cfg_pre_len), .cfg_sync(cfg_sync),
    .cfg_addr_en(cfg_addr_en), .cfg_addr(cfg_addr), .cfg_var_len(cfg_var_len),
    .cfg_len(cfg_len), .cfg_crc_en(cfg_crc_en), .cfg_code(cfg_code),
    .wr_en(wr_en), .wr_data(wr_data), .fifo_full(fifo_full), .start(start),
    .bit_tick(bit_tick), .tx_bit(tx_bit), .tx_stb(tx_stb), .busy(busy),
    .done(done), .underflow(underflow));

  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % 4;
      bit_tick = (ph == 0);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic gen();
    logic d [2048];
    int nd = 0;
    logic [15:0] c = 16'hFFFF;
    logic [8:0] l = 9'h1FF;
    nexp = 0;
    for (int p = 0; p < int'(cfg_pre_len); p++)
      for (int b = 7; b >= 0; b--) begin exp_b[nexp] = b[0]; nexp++; end
    for (int b = 15; b >= 0; b--) begin exp_b[nexp] = SYNCV[b]; nexp++; end
    if (cfg_addr_en) for (int b = 7; b >= 0; b--) begin d[nd] = cfg_addr[b]; nd++; end
    if (cfg_var_len) for (int b = 7; b >= 0; b--) begin d[nd] = cfg_len[b]; nd++; end
    for (int i = 0; i < int'(cfg_len); i++)
      for (int b = 7; b >= 0; b--) begin d[nd] = pay[i][b]; nd++; end
    for (int i = 0; i < nd; i++)
      c = {c[14:0], 1'b0} ^ ((c[15] ^ d[i]) ? 16'h1021 : 16'h0000);
    if (cfg_crc_en) for (int b = 15; b >= 0; b--) begin d[nd] = c[b]; nd++; end
    for (int i = 0; i < nd; i++) begin
      if (cfg_code == 2'd1) begin
        exp_b[nexp] = d[i]; exp_b[nexp+1] = ~d[i]; nexp += 2;
      end else if (cfg_code == 2'd2) begin
        exp_b[nexp] = d[i] ^ l[8]; nexp++;
        l = {l[7:0], l[8] ^ l[4]};
      end else begin
        exp_b[nexp] = d[i]; nexp++;
      end
    end
  endtask

  task automatic run(input int poke);
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    ngot = 0; dn = 0; uf = 0;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      start = (i == poke);
      if (tx_stb) begin got_b[ngot] = tx_bit; ngot++; end
      if (done) dn = 1;
      if (underflow) uf = 1;
      if (dn || uf) break;
    end
    start = 0;
  endtask

  function automatic int mism();
    for (int i = 0; i < nexp && i < ngot; i++)
      if (got_b[i] !== exp_b[i]) return i;
    return -1;
  endfunction

  task automatic setv(input logic [24:0] v);
    {cfg_pre_len, cfg_addr_en, cfg_var_len, cfg_crc_en, cfg_code, cfg_len, cfg_addr} = v;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!busy && !tx_stb && !done && !underflow && !fifo_full, "R12 reset state",
        {busy, tx_stb, done, underflow, fifo_full}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !fifo_full, "R12 idle after reset", {busy, fifo_full}, 0);

    for (int v = 0; v < NV; v++) begin
      setv(VEC[v]);
      for (int i = 0; i < int'(cfg_len); i++) begin
        pay[i] = 8'(i * 29 + v * 7 + 3);
        wr(pay[i]);
      end
      gen();
      run(-1);
      chk(ngot == nexp, "R1 R2 R3 R4 R5 slot count", ngot, nexp);
      chk(mism() == -1, "R1 R4 R5 R6 R7 first bad slot", mism(), -1);
      chk(dn && !uf, "R8 done pulse", dn, 1);
    end

    // R9: declared 4 payload bytes, only 2 queued
    setv({4'd1, 1'b0, 1'b0, 1'b1, 2'd0, 8'd4, 8'h00});
    pay[0] = 8'h11; pay[1] = 8'h22;
    wr(pay[0]); wr(pay[1]);
    gen();
    run(-1);
    chk(uf && !dn, "R9 underflow without done", {uf, dn}, 2);
    chk(ngot == 8 + 16 + 16, "R9 slots before abort", ngot, 40);
    chk(mism() == -1, "R9 prefix intact", mism(), -1);

    // R10: fill, overfill, drain
    for (int i = 0; i < 64; i++) begin
      pay[i] = 8'(i * 13 + 1);
      wr(pay[i]);
    end
    chk(fifo_full, "R10 full at depth", fifo_full, 1);
    wr(8'hEE);
    chk(fifo_full, "R10 still full", fifo_full, 1);
    setv({4'd1, 1'b0, 1'b0, 1'b0, 2'd0, 8'd64, 8'h00});
    gen();
    run(-1);
    chk(dn && mism() == -1 && ngot == nexp, "R10 R4 drained in order", mism(), -1);
    chk(!fifo_full, "R10 not full after drain", fifo_full, 0);
    setv({4'd0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd1, 8'h00});
    run(-1);
    chk(uf && !dn, "R10 dropped write not stored", {uf, dn}, 2);

    // R11: start pulse mid-packet
    setv({4'd2, 1'b1, 1'b0, 1'b1, 2'd2, 8'd2, 8'h3C});
    pay[0] = 8'hA5; pay[1] = 8'h0F;
    wr(pay[0]); wr(pay[1]);
    gen();
    run(60);
    chk(dn && ngot == nexp && mism() == -1, "R11 stream unchanged", mism(), -1);
    begin
      int extra = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (tx_stb || busy) extra++;
      end
      chk(extra == 0, "R11 no restart", extra, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule